// File: doc/BRIEF.md
# MII Management Interface Master

This block is a master for the two-wire PHY management interface. It runs clause-22 read and write frames to an external PHY, and a host drives it through a small register port. The port carries a clock divisor, a command register, a PHY/register address, write data, read data and an indicator register.

A write frame starts as soon as the host stores a value into the write-data register. A read frame starts when the host sets the read bit of the command register. A scan bit makes the block re-issue reads of the same address back to back. A not-valid flag tells the host whether the read-data register holds the result of a finished read.

The management clock is the system clock divided by a programmable 8-bit value. Software must pick a divisor that keeps the management clock at or below 2.5 MHz.

Top module: `mdio_master`

## Requirements
- R1: After reset the divisor register reads 40, and the indicator, read-data, write-data and address registers read 0.
- R2: The register select codes are 0 divisor, 1 command, 2 address, 3 write data, 4 read data and 5 indicator. The address register holds the PHY address in bits 12:8 and the register number in bits 4:0, and it reads back as written.
- R3: A write frame is sent as 64 bits, each driven with output enable high, in this order: 32 ones, 01, 01, the 5-bit PHY address, the 5-bit register number, 10, and then 16 data bits MSB first.
- R4: Writing the write-data register while idle starts a write frame. The frame uses the current address register and the written low 16 bits, and the write-data register reads back those 16 bits.
- R5: Writing command bit 0 as 1 while idle starts a read frame: 32 ones, 01, 10, the PHY address and the register number. Output enable then goes low for the remaining 18 bit times (turnaround and data).
- R6: During a read, the data input is sampled on each rising management-clock edge of the last 16 bit times, MSB first. The read-data register bits 15:0 then hold the captured value.
- R7: The indicator bit 2 (not valid) sets when a read frame starts and clears once its 16 data bits have been captured.
- R8: The indicator bit 0 (busy) is high from the start of a frame to its end. While busy, writes to the address and write-data registers are ignored, and so is a read command.
- R9: Command bit 1 (scan) is accepted at any time and is shown as indicator bit 1. While it is set, a new read starts one idle cycle after each frame ends. Clearing it lets the frame in flight finish and then no further frame starts.
- R10: Each management-clock phase lasts max(divisor,1) system cycles. The management clock is low whenever no frame is active.
- R11: A write-data write that arrives in the same idle cycle in which a scan read would start wins: the write frame goes first and the scan read follows it.
- R12: The data output enable is low whenever no frame is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select code |
| reg_wdata_i | input | 32 | Register write value |
| reg_rdata_o | output | 32 | Value of the selected register |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The two functions that can fall in one cycle are the scan engine's automatic restart and a host-started write. They collide in the single idle cycle between two scan frames. The bench provokes this by enabling scan, polling the indicator at every falling system-clock edge until busy drops, and issuing a write-data access in exactly that cycle. It then judges the outcome by the order of frames decoded on the wires (read, write, read) and by the indicator showing busy with not-valid clear right after the write is accepted.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    SEL_DIV   = 3'd0,
    SEL_CMD   = 3'd1,
    SEL_ADDR  = 3'd2,
    SEL_WDATA = 3'd3,
    SEL_RDATA = 3'd4,
    SEL_STAT  = 3'd5
  } reg_sel_e;

  localparam int CMD_READ  = 0;
  localparam int CMD_SCAN  = 1;
  localparam int STAT_BUSY = 0;
  localparam int STAT_SCAN = 1;
  localparam int STAT_NV   = 2;
  localparam int PHY_LSB   = 8;
  localparam int REG_LSB   = 0;
  localparam int DIV_RST   = 40;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, half;
  logic             mdc_q, tick;

  assign half = (div_i == '0) ? DIV_W'(1) : div_i;
  assign tick = run_i && (cnt_q == half - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame #(
  parameter int PRE_BITS = 32,
  parameter int ADR_W    = 5,
  parameter int DATA_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              read_i,
  input  logic [ADR_W-1:0]  phy_i,
  input  logic [ADR_W-1:0]  reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdi_i,
  output logic              busy_o,
  output logic              mdo_o,
  output logic              oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HDR_BITS   = PRE_BITS + 4 + 2 * ADR_W;
  localparam int FRAME_BITS = HDR_BITS + 2 + DATA_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sr_q, frame_word;
  logic [IDX_W-1:0]      idx_q;
  logic [DATA_W-1:0]     cap_q;
  logic                  busy_q, rd_q, done_q, last;

  assign frame_word = {{PRE_BITS{1'b1}}, 2'b01,
                       read_i ? 2'b10 : 2'b01, phy_i, reg_i,
                       read_i ? 2'b11 : 2'b10,
                       read_i ? {DATA_W{1'b1}} : wdata_i};
  assign last = (idx_q == IDX_W'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      idx_q  <= '0;
      cap_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        sr_q   <= frame_word;
        idx_q  <= '0;
        busy_q <= 1'b1;
        rd_q   <= read_i;
      end else if (busy_q) begin
        // capture on rising clock edge of the data bit times
        if (rise_i && rd_q && idx_q >= IDX_W'(FRAME_BITS - DATA_W)) begin
          cap_q  <= {cap_q[DATA_W-2:0], mdi_i};
          done_q <= last;
        end
        if (fall_i) begin
          if (last) busy_q <= 1'b0;
          else begin
            idx_q <= idx_q + IDX_W'(1);
            sr_q  <= sr_q << 1;
          end
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign mdo_o   = busy_q && sr_q[FRAME_BITS-1];
  assign oe_o    = busy_q && (!rd_q || idx_q < IDX_W'(HDR_BITS));
  assign done_o  = done_q;
  assign rdata_o = cap_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int ADR_W  = 5,
  parameter int DATA_W = 16,
  parameter int REG_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  input  logic             mdio_i
);
  logic [DIV_W-1:0]  div_q;
  logic [ADR_W-1:0]  phy_q, regad_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, cap;
  logic              scan_q, nv_q;
  logic              busy, rise, fall, done;
  logic              start_wr, rd_cmd, start_rd;
  logic              unused_hi;

  assign unused_hi = ^reg_wdata_i[REG_W-1:DATA_W];

  assign start_wr = reg_we_i && (reg_sel_i == SEL_WDATA) && !busy;
  assign rd_cmd   = reg_we_i && (reg_sel_i == SEL_CMD) && reg_wdata_i[CMD_READ];
  // host write wins over a pending scan restart
  assign start_rd = !busy && !start_wr && (rd_cmd || scan_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= DIV_W'(DIV_RST);
      phy_q   <= '0;
      regad_q <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      scan_q  <= 1'b0;
      nv_q    <= 1'b0;
    end else begin
      if (reg_we_i && reg_sel_i == SEL_DIV) div_q <= reg_wdata_i[DIV_W-1:0];
      if (reg_we_i && reg_sel_i == SEL_CMD) scan_q <= reg_wdata_i[CMD_SCAN];
      if (reg_we_i && reg_sel_i == SEL_ADDR && !busy) begin
        phy_q   <= reg_wdata_i[PHY_LSB +: ADR_W];
        regad_q <= reg_wdata_i[REG_LSB +: ADR_W];
      end
      if (start_wr) wdata_q <= reg_wdata_i[DATA_W-1:0];
      if (done) rdata_q <= cap;
      if (start_rd) nv_q <= 1'b1;
      else if (done) nv_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_sel_i)
      SEL_DIV:   reg_rdata_o = REG_W'(div_q);
      SEL_CMD:   reg_rdata_o = REG_W'({scan_q, 1'b0});
      SEL_ADDR:  reg_rdata_o = REG_W'({phy_q, 3'b000, regad_q});
      SEL_WDATA: reg_rdata_o = REG_W'(wdata_q);
      SEL_RDATA: reg_rdata_o = REG_W'(rdata_q);
      SEL_STAT:  reg_rdata_o = REG_W'({nv_q, scan_q, busy});
      default:   reg_rdata_o = '0;
    endcase
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .div_i  (div_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame #(.ADR_W(ADR_W), .DATA_W(DATA_W)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_wr || start_rd),
    .read_i  (start_rd),
    .phy_i   (phy_q),
    .reg_i   (regad_q),
    .wdata_i (reg_wdata_i[DATA_W-1:0]),
    .rise_i  (rise),
    .fall_i  (fall),
    .mdi_i   (mdio_i),
    .busy_o  (busy),
    .mdo_o   (mdio_o),
    .oe_o    (mdio_oe_o),
    .done_o  (done),
    .rdata_o (cap)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             rd_i,
  input logic [IDX_W-1:0] idx_i,
  input logic             done_i,
  input logic             mdc_i,
  input logic             mdo_i,
  input logic             oe_i,
  input logic             nv_i,
  input logic             scan_i,
  input logic [9:0]       addr_i
);
  p_preamble_driven_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && idx_i < IDX_W'(32) |-> mdo_i && oe_i);

  p_read_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && rd_i && idx_i >= IDX_W'(46) |-> !oe_i);

  p_nv_on_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) && rd_i |-> nv_i);

  p_nv_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !nv_i);

  p_addr_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i) |-> $stable(addr_i));

  p_scan_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) && scan_i |=> busy_i);

  p_mdc_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdc_i);

  p_oe_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !oe_i);
endmodule

bind mdio_master mdio_master_chk #(.IDX_W(6)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_i (u_frame.busy_q),
  .rd_i   (u_frame.rd_q),
  .idx_i  (u_frame.idx_q),
  .done_i (u_frame.done_q),
  .mdc_i  (mdc_o),
  .mdo_i  (mdio_o),
  .oe_i   (mdio_oe_o),
  .nv_i   (nv_q),
  .scan_i (scan_q),
  .addr_i ({phy_q, regad_q})
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0, mdi = 1'b1;
  logic [2:0]  sel = 3'd0;
  logic [31:0] wdat = '0, rdat;
  logic        mdc, mdo, oe;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  mdio_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdat), .reg_rdata_o(rdat), .mdc_o(mdc), .mdio_o(mdo),
    .mdio_oe_o(oe), .mdio_i(mdi));

  typedef struct packed { logic [63:0] bits; logic [63:0] oe; } frm_t;
  frm_t  exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic push_wr(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    exp_q.push_back('{{32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d}, {64{1'b1}}});
    tag_q.push_back("R3 R4 write frame");
  endtask

  task automatic push_rd(input logic [4:0] p, input logic [4:0] r);
    exp_q.push_back('{{32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 18'h0}, {{46{1'b1}}, 18'h0}});
    tag_q.push_back("R5 read frame");
  endtask

  // monitor / PHY model
  logic        mdc_prev = 1'b0;
  int          idx = 0, frames = 0, cyc = 0, last_rise = 0, exp_half = 40;
  logic [15:0] phy_val = '0;
  logic [63:0] got_b, got_oe;

  always @(negedge clk) begin
    cyc++;
    if (mdc && !mdc_prev) begin
      got_b[63-idx]  = mdo;
      got_oe[63-idx] = oe;
      if (idx == 1)
        chk((cyc - last_rise) == 2 * exp_half, "R10 mdc period", 64'(cyc - last_rise), 64'(2 * exp_half));
      last_rise = cyc;
      idx++;
      if (idx == 64) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected frame", got_b, 64'h0);
        else begin
          frm_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(((got_b ^ e.bits) & e.oe) == 0, t, got_b, e.bits);
          chk(got_oe == e.oe, {t, " oe"}, got_oe, e.oe);
        end
        idx = 0;
        frames++;
      end
    end
    mdc_prev = mdc;
    mdi = (idx >= 48 && idx < 64) ? phy_val[63-idx] : 1'b1;
  end

  task automatic reg_wr(input logic [2:0] s, input logic [31:0] v);
    @(negedge clk); we = 1'b1; sel = s; wdat = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] s, output logic [31:0] v);
    @(negedge clk); sel = s; #1 v = rdat;
  endtask

  task automatic wait_idle;
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      reg_rd(3'd5, v);
      if (!v[0]) break;
    end
  endtask

  task automatic wait_frames(input int n);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (frames >= n) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    reg_rd(3'd0, v); chk(v == 32'd40, "R1 divisor reset", v, 32'd40);
    reg_rd(3'd5, v); chk(v == 0, "R1 indicator reset", v, 0);
    reg_rd(3'd4, v); chk(v == 0, "R1 read data reset", v, 0);
    reg_rd(3'd3, v); chk(v == 0, "R1 write data reset", v, 0);
    chk(!mdc && !oe, "R12 idle outputs", {mdc, oe}, 0);

    exp_half = 2;
    reg_wr(3'd0, 32'd2);
    reg_wr(3'd2, 32'h0000_130A);
    reg_rd(3'd2, v); chk(v == 32'h130A, "R2 address readback", v, 32'h130A);

    // write frame, then stimulus that must be ignored while busy
    push_wr(5'h13, 5'h0A, 16'hA5C3);
    reg_wr(3'd3, 32'hFFFF_A5C3);
    reg_rd(3'd5, v); chk(v == 32'h1, "R8 busy during write", v, 32'h1);
    reg_wr(3'd2, 32'h0000_0105);
    reg_wr(3'd3, 32'h0000_1111);
    reg_wr(3'd1, 32'h1);
    reg_rd(3'd5, v); chk(v == 32'h1, "R8 read cmd ignored while busy", v, 32'h1);
    wait_idle();
    reg_rd(3'd2, v); chk(v == 32'h130A, "R8 address write ignored", v, 32'h130A);
    reg_rd(3'd3, v); chk(v == 32'hA5C3, "R4 write data readback", v, 32'hA5C3);
    chk(!mdc && !oe, "R10 R12 idle after write", {mdc, oe}, 0);

    // single read
    phy_val = 16'h3C5A;
    push_rd(5'h13, 5'h0A);
    reg_wr(3'd1, 32'h1);
    reg_rd(3'd5, v); chk(v == 32'h5, "R7 nv set at read start", v, 32'h5);
    wait_idle();
    reg_rd(3'd4, v); chk(v == 32'h3C5A, "R6 read data captured", v, 32'h3C5A);
    reg_rd(3'd5, v); chk(v == 32'h0, "R7 nv cleared after read", v, 32'h0);

    // divisor zero behaves as one
    reg_wr(3'd0, 32'd0);
    exp_half = 1;
    reg_wr(3'd2, 32'h0000_1F11);
    push_wr(5'h1F, 5'h11, 16'h8001);
    reg_wr(3'd3, 32'h0000_8001);
    wait_idle();
    reg_wr(3'd0, 32'd2);
    exp_half = 2;

    // scan mode
    phy_val = 16'h1234;
    base = frames;
    push_rd(5'h1F, 5'h11); push_rd(5'h1F, 5'h11); push_rd(5'h1F, 5'h11);
    reg_wr(3'd1, 32'h2);
    reg_rd(3'd5, v); chk(v[1:0] == 2'b11, "R9 scan indicator", v, 32'h3);
    wait_frames(base + 2);
    reg_rd(3'd4, v); chk(v == 32'h1234, "R9 scan read data", v, 32'h1234);
    phy_val = 16'hBEEF;
    repeat (20) @(negedge clk);
    reg_wr(3'd1, 32'h0);
    wait_idle();
    reg_rd(3'd4, v); chk(v == 32'hBEEF, "R9 scan refreshed data", v, 32'hBEEF);
    reg_rd(3'd5, v); chk(v == 32'h0, "R9 scan stopped", v, 32'h0);
    repeat (300) @(negedge clk);
    chk(frames == base + 3, "R9 no frame after scan cleared", 64'(frames), 64'(base + 3));

    // collision: write-data write in the scan restart cycle
    phy_val = 16'h0A0A;
    base = frames;
    push_rd(5'h1F, 5'h11); push_wr(5'h1F, 5'h11, 16'h0F0F); push_rd(5'h1F, 5'h11);
    reg_wr(3'd1, 32'h2);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); sel = 3'd5; #1;
      if (!rdat[0]) begin
        we = 1'b1; sel = 3'd3; wdat = 32'h0000_0F0F;
        break;
      end
    end
    @(negedge clk); we = 1'b0;
    reg_rd(3'd5, v); chk(v == 32'h3, "R11 write wins restart cycle", v, 32'h3);
    wait_frames(base + 2);
    repeat (20) @(negedge clk);
    reg_wr(3'd1, 32'h0);
    wait_idle();
    reg_rd(3'd4, v); chk(v == 32'h0A0A, "R11 scan read after write", v, 32'h0A0A);
    repeat (50) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected frames seen", 64'(exp_q.size()), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule